// File: doc/BRIEF.md
# Dual Event Counter Unit

This block is a small performance-monitoring unit with two 32-bit event counters and one 64-bit control word. Each counter watches one line of a wide vector of event pulses. The line is chosen by a 12-bit code held in the control word. A counter adds one in any cycle where its chosen pulse is high and the unit is allowed to count in the current privilege context (user, supervisor or hypervisor). The context permissions are shared by both counters. Clearing all three stops both counters together.

There is no separate per-counter stop. To park a counter that is not in use, software points it at a code whose event practically never fires. Code 0x220, which counts a rarely executed no-op form, is the usual choice. A counter that passes from 0xFFFFFFFF to zero latches an overflow flag. Each flag has its own interrupt enable, and the interrupt output is a level. Any write to the control word clears both flags, which is how software acknowledges the interrupt. Software reads and writes the two counters together as a single 64-bit word through a plain register port.

Top module: `dual_event_counter`

## Requirements
- R1: While `rst_n` is low at a clock edge, both counters, the control word and both overflow flags are cleared, so after that edge `rd_data` reads zero at both addresses and `irq` is low.
- R2: A read at address 0 returns the counter word. The upper counter is in bits 63:32 and the lower counter is in bits 31:0. A write at address 0 loads both counters from `wr_data` in the same split.
- R3: A counter adds exactly one at a clock edge when its selected event pulse is high and the enable for the present context is set. `ctx` is encoded 0 = user (enable bit 2), 1 = supervisor (enable bit 1), 2 = hypervisor (enable bit 3) and 3 = no context, which never counts.
- R4: The three context enables apply to both counters at once. When the enable for the present context is clear, neither counter moves, whatever the event pulses do.
- R5: The upper counter's event code is control bits 30:19 and the lower counter's is bits 17:6. A code at or above the number of event lines never counts. A parked code such as 0x220 counts only its own pulse.
- R6: An increment from 0xFFFFFFFF to zero latches that counter's overflow flag.
- R7: `irq` is high while any latched flag has its enable set. Bit 4 enables the lower counter's flag and bit 5 enables the upper counter's flag. A flag whose enable is clear leaves `irq` low.
- R8: Any write to the control word clears both overflow flags. This takes priority over a wrap in the same cycle, so `irq` is low after the write.
- R9: A counter-word write takes priority over an increment in the same cycle. After the counter word is loaded with 0xFFFFFFFF, one qualifying event gives a wrap and an overflow.
- R10: A read at address 1 returns the full 64-bit value last written to the control word. Counting in the cycle of a control write follows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | EVT_COUNT | Event pulses, one line per event code |
| ctx | input | 2 | Present privilege context (0 user, 1 supervisor, 2 hypervisor, 3 none) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 counter word, 1 control word |
| wr_data | input | 64 | Write data |
| rd_addr | input | 1 | Read target: 0 counter word, 1 control word |
| rd_data | output | 64 | Read data, combinational from the registers |
| irq | output | 1 | Level overflow interrupt |

## Verification
Every register effect is due at the first clock edge after the stimulus cycle. Increments, loads, control writes, flag set and flag clear all appear on `rd_data` and `irq` straight after that edge, with no further pipeline stage. `rd_data` follows `rd_addr` within the same cycle. The bench therefore drives inputs at the falling edge and makes its directed checks at the next falling edge, one full edge later. A behavioural model is advanced at every rising edge and compared shortly after it, so every cycle counts as a check, including the cycles where a write and an event collide.

// File: rtl/pcu_pkg.sv
// Shared constants and types for the dual event counter unit.
// Assumes two counters of equal width packed into one 64-bit word.
package pcu_pkg;
    localparam int CNT_W      = 32;
    localparam int NUM_CNT    = 2;
    localparam int WORD_W     = CNT_W * NUM_CNT;
    localparam int SEL_W      = 12;
    localparam int SEL_LSB_LO = 6;
    localparam int SEL_LSB_HI = 19;
    localparam int EN_SUP_BIT = 1;
    localparam int EN_USR_BIT = 2;
    localparam int EN_HYP_BIT = 3;
    localparam int IE_LO_BIT  = 4;
    localparam int IE_HI_BIT  = 5;
    localparam logic [SEL_W-1:0] PARK_CODE = 12'h220;

    typedef enum logic [1:0] {
        CTX_USER  = 2'd0,
        CTX_SUPER = 2'd1,
        CTX_HYPER = 2'd2,
        CTX_NONE  = 2'd3
    } ctx_e;
endpackage

// File: rtl/pcu_counter.sv
// One event counter: picks its event line by code, increments when allowed,
// accepts a software load with priority and flags the all-ones to zero wrap.
// Assumes EVT_COUNT is at most 2**SEL_W; codes past EVT_COUNT read as idle.
module pcu_counter #(
    parameter int CNT_W     = 32,
    parameter int SEL_W     = 12,
    parameter int EVT_COUNT = 1024
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [EVT_COUNT-1:0] evt_pulse,
    input  logic [SEL_W-1:0]     sel,
    input  logic                 count_ok,
    input  logic                 load,
    input  logic [CNT_W-1:0]     load_val,
    output logic [CNT_W-1:0]     cnt,
    output logic                 wrap
);
    localparam int SPAN = 1 << SEL_W;

    logic [SPAN-1:0] evt_span;
    logic            hit;
    logic            inc;

    // Widen the event vector to the full code space so every code indexes.
    generate
        if (EVT_COUNT < SPAN) begin : g_pad
            assign evt_span = {{(SPAN-EVT_COUNT){1'b0}}, evt_pulse};
        end else begin : g_trim
            assign evt_span = evt_pulse[SPAN-1:0];
        end
    endgenerate

    // Event selection and qualification for this cycle.
    always_comb begin
        hit  = evt_span[sel];
        inc  = hit && count_ok;
        wrap = inc && !load && (&cnt);
    end

    // Counter register: reset, then software load, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pcu_ctrl.sv
// Control word, context gating and overflow flags with the level interrupt.
// Assumes wrap[0] belongs to the lower counter and wrap[1] to the upper one.
module pcu_ctrl
    import pcu_pkg::*;
#(
    parameter int WORD_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [1:0]        ctx,
    input  logic [1:0]        wrap,
    output logic [WORD_W-1:0] ctrl_q,
    output logic              count_ok,
    output logic              irq
);
    logic [1:0] ovf_q;
    logic [1:0] ie;

    // Control word register, fully writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= wr_data;
        end
    end

    // Shared context gate for both counters.
    always_comb begin
        unique case (ctx_e'(ctx))
            CTX_USER:  count_ok = ctrl_q[EN_USR_BIT];
            CTX_SUPER: count_ok = ctrl_q[EN_SUP_BIT];
            CTX_HYPER: count_ok = ctrl_q[EN_HYP_BIT];
            default:   count_ok = 1'b0;
        endcase
    end

    // Overflow flags: a control write clears them and wins over a same-cycle wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= '0;
        end else if (ctrl_wr) begin
            ovf_q <= '0;
        end else begin
            ovf_q <= ovf_q | wrap;
        end
    end

    // Level interrupt from enabled flags.
    always_comb begin
        ie  = {ctrl_q[IE_HI_BIT], ctrl_q[IE_LO_BIT]};
        irq = |(ovf_q & ie);
    end
endmodule

// File: rtl/dual_event_counter.sv
// Top of the dual event counter unit: register port decode, two counters
// built by generate, and the shared control block.
// Assumes single-cycle register access; reads are combinational.
module dual_event_counter
    import pcu_pkg::*;
#(
    parameter int EVT_COUNT = 1024
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [EVT_COUNT-1:0] evt_pulse,
    input  logic [1:0]           ctx,
    input  logic                 wr_en,
    input  logic                 wr_addr,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic                 rd_addr,
    output logic [WORD_W-1:0]    rd_data,
    output logic                 irq
);
    logic              cnt_wr;
    logic              ctrl_wr;
    logic              count_ok;
    logic [WORD_W-1:0] ctrl_q;
    logic [WORD_W-1:0] cnt_word;
    logic [1:0]        wrap_vec;

    // Register port write decode.
    always_comb begin
        cnt_wr  = wr_en && !wr_addr;
        ctrl_wr = wr_en && wr_addr;
    end

    pcu_ctrl #(
        .WORD_W (WORD_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .wr_data  (wr_data),
        .ctx      (ctx),
        .wrap     (wrap_vec),
        .ctrl_q   (ctrl_q),
        .count_ok (count_ok),
        .irq      (irq)
    );

    // Counter 0 is the lower half of the word, counter 1 the upper half.
    generate
        for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
            localparam int SEL_LSB = (i == 0) ? SEL_LSB_LO : SEL_LSB_HI;
            pcu_counter #(
                .CNT_W     (CNT_W),
                .SEL_W     (SEL_W),
                .EVT_COUNT (EVT_COUNT)
            ) u_counter (
                .clk       (clk),
                .rst_n     (rst_n),
                .evt_pulse (evt_pulse),
                .sel       (ctrl_q[SEL_LSB +: SEL_W]),
                .count_ok  (count_ok),
                .load      (cnt_wr),
                .load_val  (wr_data[i*CNT_W +: CNT_W]),
                .cnt       (cnt_word[i*CNT_W +: CNT_W]),
                .wrap      (wrap_vec[i])
            );
        end
    endgenerate

    // Read mux.
    assign rd_data = rd_addr ? ctrl_q : cnt_word;
endmodule

// File: rtl/pcu_checker.sv
// Temporal checks on the dual event counter unit, bound to its top.
module pcu_checker
    import pcu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_addr,
    input logic [WORD_W-1:0] wr_data,
    input logic [WORD_W-1:0] cnt_word,
    input logic [WORD_W-1:0] ctrl_q,
    input logic [1:0]        wrap_vec,
    input logic              irq
);
    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (cnt_word == '0 && ctrl_q == '0 && !irq)); // R1

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && !wr_addr) |=> cnt_word == $past(wr_data)); // R9

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n) !(wr_en && !wr_addr) |=> (cnt_word[CNT_W-1:0] == $past(cnt_word[CNT_W-1:0]) || cnt_word[CNT_W-1:0] == $past(cnt_word[CNT_W-1:0]) + 32'd1)); // R3

    AST_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n) (ctrl_q[EN_HYP_BIT:EN_SUP_BIT] == 3'b000 && !(wr_en && !wr_addr)) |=> $stable(cnt_word)); // R4

    AST_CTRL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_addr) |=> !irq); // R8

    AST_IRQ_FROM_WRAP: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq) |-> $past(|wrap_vec)); // R6
endmodule

bind dual_event_counter pcu_checker u_pcu_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .cnt_word (cnt_word),
    .ctrl_q   (ctrl_q),
    .wrap_vec (wrap_vec),
    .irq      (irq)
);

// File: tb/dual_event_counter_bench.sv
module dual_event_counter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int EVT = 1024;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [EVT-1:0] evt_pulse;
    logic [1:0]     ctx;
    logic           wr_en;
    logic           wr_addr;
    logic [63:0]    wr_data;
    logic           rd_addr;
    logic [63:0]    rd_data;
    logic           irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    dual_event_counter #(.EVT_COUNT(EVT)) u_dual_event_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_pulse (evt_pulse),
        .ctx       (ctx),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model
    logic [31:0] m_cnt [2];
    logic [31:0] m_nxt [2];
    logic [63:0] m_ctrl;
    logic [1:0]  m_flag;
    logic [1:0]  m_wrap;
    bit          m_en;
    int          m_code;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt[0] = 0; m_cnt[1] = 0; m_ctrl = 0; m_flag = 0;
        end else begin
            case (ctx)
                2'd0: m_en = m_ctrl[2];
                2'd1: m_en = m_ctrl[1];
                2'd2: m_en = m_ctrl[3];
                default: m_en = 0;
            endcase
            m_wrap = 0;
            for (int i = 0; i < 2; i++) begin
                m_code = (i == 0) ? int'(m_ctrl[17:6]) : int'(m_ctrl[30:19]);
                m_nxt[i] = m_cnt[i];
                if (wr_en && !wr_addr) begin
                    m_nxt[i] = wr_data[i*32 +: 32];
                end else if (m_en && m_code < EVT) begin
                    if (evt_pulse[m_code]) begin
                        if (m_cnt[i] == 32'hFFFF_FFFF) m_wrap[i] = 1;
                        m_nxt[i] = m_cnt[i] + 1;
                    end
                end
            end
            m_cnt[0] = m_nxt[0];
            m_cnt[1] = m_nxt[1];
            if (wr_en && wr_addr) begin
                m_flag = 0;
                m_ctrl = wr_data;
            end else begin
                m_flag = m_flag | m_wrap;
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, just after each rising edge
    always begin
        @(posedge clk);
        #1;
        if (!finished) begin
            chk("R2 model word/ctrl", rd_data, rd_addr ? m_ctrl : {m_cnt[1], m_cnt[0]});
            chk("R7 model irq", {63'd0, irq}, {63'd0, |(m_flag & {m_ctrl[5], m_ctrl[4]})});
        end
    end

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic put_ctrl(input logic [63:0] v);
        wr_en = 1; wr_addr = 1; wr_data = v;
        cyc();
        wr_en = 0;
    endtask

    task automatic put_cnt(input logic [63:0] v);
        wr_en = 1; wr_addr = 0; wr_data = v;
        cyc();
        wr_en = 0;
    endtask

    function automatic logic [63:0] cw(input int hi, input int lo, input logic [5:0] low_bits);
        return (64'(hi) << 19) | (64'(lo) << 6) | 64'(low_bits);
    endfunction

    initial begin
        #(CLK_PERIOD * 5000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [63:0] c;
        rst_n = 0; evt_pulse = '0; ctx = 0; wr_en = 0; wr_addr = 0; wr_data = '0; rd_addr = 0;
        repeat (3) cyc();
        // R1 reset state
        chk("R1 counter word", rd_data, 64'd0);
        chk("R1 irq", {63'd0, irq}, 64'd0);
        rd_addr = 1; #1;
        chk("R1 control", rd_data, 64'd0);
        rd_addr = 0;
        rst_n = 1;

        // R10 readback
        c = cw(9, 5, 6'h04);
        put_ctrl(c);
        rd_addr = 1; #1;
        chk("R10 control readback", rd_data, c);
        rd_addr = 0;

        // R3 counting under user context
        ctx = 0; evt_pulse[5] = 1; evt_pulse[9] = 1;
        cyc();
        evt_pulse[9] = 0;
        cyc(); cyc();
        evt_pulse[5] = 0;
        chk("R3 user counting", rd_data, {32'd1, 32'd3});

        // R4 shared context gating
        ctx = 1; evt_pulse[5] = 1; evt_pulse[9] = 1;
        cyc(); cyc();
        chk("R4 supervisor disabled", rd_data, {32'd1, 32'd3});
        ctx = 2; cyc();
        chk("R4 hypervisor disabled", rd_data, {32'd1, 32'd3});
        ctx = 3; cyc();
        chk("R4 no context", rd_data, {32'd1, 32'd3});
        ctx = 2;
        put_ctrl(cw(9, 5, 6'h08));
        chk("R10 old control during write", rd_data, {32'd1, 32'd3});
        cyc();
        chk("R4 hypervisor enabled", rd_data, {32'd2, 32'd4});
        evt_pulse = '0;

        // R5 out-of-range code and parked code
        ctx = 0;
        evt_pulse = '1; evt_pulse[12'h220] = 0;
        put_ctrl(cw(12'h220, 12'hFFF, 6'h04));
        cyc(); cyc();
        chk("R5 parked and out-of-range", rd_data, {32'd2, 32'd4});
        evt_pulse[12'h220] = 1;
        cyc();
        chk("R5 parked code own pulse", rd_data, {32'd3, 32'd4});
        evt_pulse = '0;

        // R9 load priority then R6 wrap with interrupt
        ctx = 1;
        put_ctrl(cw(9, 5, 6'h12));
        evt_pulse[5] = 1; evt_pulse[9] = 1;
        put_cnt({32'h10, 32'hFFFF_FFFE});
        chk("R9 load beats increment", rd_data, {32'h10, 32'hFFFF_FFFE});
        cyc();
        chk("R6 no irq before wrap", {63'd0, irq}, 64'd0);
        cyc();
        evt_pulse = '0;
        chk("R6 lower wrap word", rd_data, {32'h12, 32'h0});
        chk("R6 irq after wrap", {63'd0, irq}, 64'd1);

        // R8 control write acknowledges
        put_ctrl(cw(9, 5, 6'h32));
        chk("R8 irq cleared", {63'd0, irq}, 64'd0);

        // R7 upper wrap with its enable clear
        put_ctrl(cw(9, 5, 6'h12));
        evt_pulse[9] = 1;
        put_cnt({32'hFFFF_FFFF, 32'h0});
        cyc();
        evt_pulse = '0;
        chk("R7 upper wrapped", rd_data, {32'h0, 32'h0});
        chk("R7 masked flag keeps irq low", {63'd0, irq}, 64'd0);
        put_ctrl(cw(9, 5, 6'h32));
        chk("R8 write clears masked flag", {63'd0, irq}, 64'd0);

        // R8 clear wins over same-cycle wrap
        put_cnt({32'h0, 32'hFFFF_FFFF});
        evt_pulse[5] = 1;
        put_ctrl(cw(9, 5, 6'h32));
        evt_pulse = '0;
        chk("R8 clear beats wrap", {63'd0, irq}, 64'd0);
        chk("R8 wrap still counted", rd_data, {32'h0, 32'h0});

        // R9 load all-ones then one event overflows
        put_cnt({32'h0, 32'hFFFF_FFFF});
        evt_pulse[5] = 1;
        cyc();
        evt_pulse = '0;
        chk("R9 load then event irq", {63'd0, irq}, 64'd1);

        cyc();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule